// File: doc/BRIEF.md
# Masked-Write GPIO Bank

A single general-purpose I/O bank of up to 32 pins on a plain 32-bit register bus (address, write enable, write data, registered read data). It holds three registers: output data, direction and output enable. A pin's pad drives only while both its direction bit and its output-enable bit are 1. The value driven is the matching output data bit. Pin inputs are sampled through a two-flop synchronizer, and software can read them back.

The output data register can be written as a whole word. It can also be written one 16-bit half at a time through two masked-write ports. In each such write the upper 16 bits of the bus word form a per-bit keep mask, and the lower 16 bits carry the new values. One pin can therefore change in a single bus write, with no read-modify-write. The parameter `NUM_PINS` sets how many pins are implemented. The rest read as zero and cannot be written.

Top module: `gpio_bank_mw`

## Requirements
- R1: After the active-low asynchronous reset, the output data, direction and output-enable registers are all zero, `pin_oe_o` is zero and `rdata_o` is zero.
- R2: A write to offset 0x000 updates pins 0..15 only. For each b in 0..15, data bit b takes `wdata_i[b]` when `wdata_i[16+b]` is 0 and keeps its value when that bit is 1. Pins 16..31 are unchanged.
- R3: A write to offset 0x004 updates pins 16..31 only. For each b in 0..15, data bit 16+b takes `wdata_i[b]` when `wdata_i[16+b]` is 0 and keeps its value when that bit is 1. Pins 0..15 are unchanged.
- R4: Offset 0x040 reads and writes the whole output data register as one word.
- R5: Offset 0x060 reads the pin inputs after two synchronizing flops, so a change on `pin_i` can be read once two clock edges have passed. Writes to 0x060 change nothing.
- R6: Offset 0x204 is the direction register (1 = output) and offset 0x208 is the output-enable register. Both can be read and written as words.
- R7: `pin_o` equals the output data register. `pin_oe_o[n]` is 1 exactly when direction bit n and output-enable bit n are both 1.
- R8: Pins at index NUM_PINS and above read 0 in every register. Writes to them are ignored, and `pin_o` and `pin_oe_o` are 0 for them.
- R9: `rdata_o` shows, one cycle after an address is presented, the register contents from before any write on that same edge. A write takes effect on the edge where `we_i` is sampled. Unmapped offsets and the two masked-write ports read 0, and a write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Pad input values |
| pin_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad drive enables |

## Verification
The bench uses a bank with 26 implemented pins, so that the dead upper bits are exercised. The half-word ports are driven with all-take, all-keep and split masks, each over a known data pattern. This separates a swapped mask sense, a swapped half and leakage into the other half. Direction and output enable are driven in different patterns, so a drive enable built from only one of them shows up. Input patterns on the pins are read through the synchronizer at the earliest valid cycle. Writes to the read-only and unmapped offsets are followed by data readback to show they changed nothing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DW     = 32;
  localparam int ADDR_W = 12;
  localparam int HALF   = DW / 2;

  localparam logic [ADDR_W-1:0] A_MW_LO  = 12'h000;
  localparam logic [ADDR_W-1:0] A_MW_HI  = 12'h004;
  localparam logic [ADDR_W-1:0] A_DATA   = 12'h040;
  localparam logic [ADDR_W-1:0] A_PIN_IN = 12'h060;
  localparam logic [ADDR_W-1:0] A_DIR    = 12'h204;
  localparam logic [ADDR_W-1:0] A_OE     = 12'h208;

  function automatic logic [DW-1:0] impl_mask(int n);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < n);
    return m;
  endfunction

  // keep bit where mask is 1, take new value where mask is 0
  function automatic logic [HALF-1:0] merge_half(logic [HALF-1:0] cur, logic [DW-1:0] wd);
    return (cur & wd[DW-1:HALF]) | (wd[HALF-1:0] & ~wd[DW-1:HALF]);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign dout_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     data_o,
  output logic [DW-1:0]     dir_o,
  output logic [DW-1:0]     oe_o
);
  localparam logic [DW-1:0] IMPL = impl_mask(NUM_PINS);

  logic [DW-1:0] data_q, dir_q, oe_q;
  logic [DW-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (we_i) begin
      unique case (addr_i)
        A_MW_LO: data_d[HALF-1:0]  = merge_half(data_q[HALF-1:0], wdata_i);
        A_MW_HI: data_d[DW-1:HALF] = merge_half(data_q[DW-1:HALF], wdata_i);
        A_DATA:  data_d            = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      oe_q   <= '0;
    end else begin
      data_q <= data_d & IMPL;
      if (we_i && addr_i == A_DIR) dir_q <= wdata_i & IMPL;
      if (we_i && addr_i == A_OE)  oe_q  <= wdata_i & IMPL;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic [DW-1:0]     pins_i,
  input  logic [DW-1:0]     dir_i,
  input  logic [DW-1:0]     oe_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] rd_d, rd_q;

  always_comb begin
    unique case (addr_i)
      A_DATA:   rd_d = data_i;
      A_PIN_IN: rd_d = pins_i;
      A_DIR:    rd_d = dir_i;
      A_OE:     rd_d = oe_i;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/gpio_bank_mw.sv
module gpio_bank_mw
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [11:0] addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] pin_i,
  output logic [31:0] pin_o,
  output logic [31:0] pin_oe_o
);
  localparam logic [DW-1:0] IMPL = impl_mask(NUM_PINS);

  logic [DW-1:0] data_q, dir_q, oe_q, pins_sync;

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .data_o(data_q), .dir_o(dir_q), .oe_o(oe_q)
  );

  gpio_in_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .din_i(pin_i & IMPL), .dout_o(pins_sync)
  );

  gpio_rd_mux u_rd (
    .clk_i, .rst_ni, .addr_i,
    .data_i(data_q), .pins_i(pins_sync), .dir_i(dir_q), .oe_i(oe_q),
    .rdata_o
  );

  assign pin_o    = data_q;
  assign pin_oe_o = dir_q & oe_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] addr_i,
  input logic        we_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic [31:0] pin_i,
  input logic [31:0] pin_o,
  input logic [31:0] pin_oe_o
);
  localparam logic [DW-1:0] IMPL = impl_mask(NUM_PINS);
  logic unmapped;
  assign unmapped = !(addr_i inside {A_DATA, A_PIN_IN, A_DIR, A_OE});

  p_lo_keeps_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MW_LO) |=> pin_o[31:16] == $past(pin_o[31:16]));

  p_lo_merge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MW_LO) |=> pin_o[15:0] ==
      ((($past(pin_o[15:0]) & $past(wdata_i[31:16])) |
        ($past(wdata_i[15:0]) & ~$past(wdata_i[31:16]))) & IMPL[15:0]));

  p_hi_keeps_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MW_HI) |=> pin_o[15:0] == $past(pin_o[15:0]));

  p_full_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DATA) |=> pin_o == ($past(wdata_i) & IMPL));

  p_dir_readback_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIR) ##1 (!we_i && addr_i == A_DIR) |=>
      rdata_o == ($past(wdata_i, 2) & IMPL));

  p_oe_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OE && wdata_i == '0) |=> pin_oe_o == '0);

  p_drive_needs_data_reg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |=> $stable(pin_o));

  p_unimpl_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o | pin_oe_o | rdata_o) & ~IMPL) == '0);

  p_unmapped_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |=> rdata_o == '0);
endmodule

bind gpio_bank_mw gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_bank_mw_bench.sv
module gpio_bank_mw_bench;
  localparam int CLK_P = 10;
  localparam int IMPL_N = 26;
  localparam logic [31:0] IMPL = 32'h03FF_FFFF;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic we = 0;
  logic [31:0] wdata = '0, pins = '0;
  logic [31:0] rdata, pout, poe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_bank_mw #(.NUM_PINS(IMPL_N)) u_gpio_bank_mw (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pout), .pin_oe_o(poe)
  );

  // behavioural reference
  logic [31:0] m_data, m_dir, m_oe, m_rd, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_oe = 0; m_rd = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      case (addr)
        12'h040: m_rd = m_data;
        12'h060: m_rd = m_s2;
        12'h204: m_rd = m_dir;
        12'h208: m_rd = m_oe;
        default: m_rd = 0;
      endcase
      m_s2 = m_s1;
      m_s1 = pins & IMPL;
      if (we) begin
        case (addr)
          12'h000: for (int b = 0; b < 16; b++) if (!wdata[16+b]) m_data[b] = wdata[b];
          12'h004: for (int b = 0; b < 16; b++) if (!wdata[16+b]) m_data[16+b] = wdata[b];
          12'h040: m_data = wdata;
          12'h204: m_dir = wdata;
          12'h208: m_oe = wdata;
          default: ;
        endcase
        m_data &= IMPL; m_dir &= IMPL; m_oe &= IMPL;
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("R9 rdata vs model", rdata, m_rd);
      chk("R7 pin_o vs model", pout, m_data);
      chk("R7 pin_oe_o vs model", poe, m_dir & m_oe);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0; addr = 12'h100; wdata = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 0;
    @(posedge clk); #1; v = rdata;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #(CLK_P*3); #1;
    chk("R1 pin_oe_o at reset", poe, 0);
    chk("R1 rdata at reset", rdata, 0);
    @(negedge clk); rst_n = 1;
    rd(12'h204, v); chk("R1 dir reset", v, 0);
    rd(12'h040, v); chk("R1 data reset", v, 0);

    wr(12'h040, 32'hA5A5_5A5A);
    rd(12'h040, v); chk("R4 full write readback", v, 32'h01A5_5A5A);
    chk("R8 upper bits dropped", v & ~IMPL, 0);

    wr(12'h000, {16'hFF00, 16'h0033});
    rd(12'h040, v); chk("R2 split mask low half", v, 32'h01A5_5A33);
    wr(12'h000, {16'hFFFF, 16'h0000});
    rd(12'h040, v); chk("R2 all-keep mask", v, 32'h01A5_5A33);

    wr(12'h004, {16'h0000, 16'hFFFF});
    rd(12'h040, v); chk("R3 all-take high half", v, 32'h03FF_5A33);
    wr(12'h004, {16'hFFFE, 16'h0000});
    rd(12'h040, v); chk("R3 single pin clear", v, 32'h03FE_5A33);
    chk("R7 pin_o matches data", pout, 32'h03FE_5A33);

    wr(12'h204, 32'hFFFF_FFFF);
    rd(12'h204, v); chk("R6 dir readback", v, IMPL);
    chk("R7 dir alone no drive", poe, 0);
    wr(12'h208, 32'h0000_00FF);
    rd(12'h208, v); chk("R6 oe readback", v, 32'h0000_00FF);
    chk("R7 dir and oe", poe, 32'h0000_00FF);
    wr(12'h204, 32'h0000_000F);
    #1; chk("R7 dir narrowed", poe, 32'h0000_000F);

    @(negedge clk); pins = 32'h1234_5678;
    @(negedge clk); rd(12'h060, v); chk("R5 synced pins", v, 32'h0234_5678);
    @(negedge clk); pins = 32'hFFFF_FFFF;
    rd(12'h060, v); chk("R5 two-flop lag", v, 32'h0234_5678);
    rd(12'h060, v); chk("R5 new value after sync", v, IMPL);
    wr(12'h060, 32'h0);
    rd(12'h040, v); chk("R5 write to input ignored", v, 32'h03FE_5A33);

    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h040, v); chk("R9 unmapped write ignored", v, 32'h03FE_5A33);
    rd(12'h000, v); chk("R9 masked port reads 0", v, 0);
    rd(12'h100, v); chk("R9 unmapped reads 0", v, 0);

    // read and write on the same edge: old value returned
    @(negedge clk); addr = 12'h040; we = 1; wdata = 32'h0000_1111;
    @(posedge clk); #1; chk("R9 read before write", rdata, 32'h03FE_5A33);
    @(negedge clk); we = 0;
    @(posedge clk); #1; chk("R9 write visible next", rdata, 32'h0000_1111);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule